// File: doc/BRIEF.md
# Timer Capture-Compare Unit

A free-running 16-bit counter feeds eight channels, each with its own 16-bit channel register. A channel in capture mode copies the counter into its register when its input pin shows the selected transition. A channel in compare mode acts on its output pin when the counter steps onto the value held in its register. Every event sets a sticky per-channel flag. Software clears a flag by writing a one to it. A masked copy of each flag drives a per-channel interrupt line.

The counter wraps from 0xFFFF to zero. The wrap sets an overflow flag, and an enable bit gates that flag onto its own interrupt output. All settings and results are reached through a small synchronous register bus. Writes are single-cycle strobes. Reads are combinational from the address.

Top module: `tcc_unit`

## Requirements
- R1: After reset, every register reads zero, all output pins are low and no interrupt output is asserted.
- R2: The counter (read at address 7, read-only) steps by one per clock while the run bit (bit 7 of address 0) is 1, and holds its value while that bit is 0.
- R3: When the counter steps from 0xFFFF to 0, the overflow flag (bit 0 of address 6) is set. `irq_ovf` is that flag ANDed with the overflow enable (bit 0 of address 0).
- R4: Channel flags (bits 7:0 of address 5) and the overflow flag are cleared only by writing 1 to their bit. A 0 leaves a flag unchanged. When a new event and a clear land on the same cycle, the flag stays set.
- R5: Bit n of the mode register (address 1) set to 1 makes channel n a compare channel, and 0 makes it a capture channel. Input edges on a compare channel are ignored. Counter matches on a capture channel are ignored.
- R6: A compare match occurs on the clock edge where the running counter steps onto the channel register value. It happens once per step, sets the flag and applies the 2-bit action field at bits 2n+1:2n of address 2: 00 no pin change, 01 toggle, 10 drive low, 11 drive high.
- R7: A capture channel uses the 2-bit edge field at bits 2n+1:2n of address 3: 00 off, 01 rising, 10 falling, 11 both. The input is synchronised through two flops. A change applied before clock edge k captures on edge k+2, storing the counter value present just before that edge and setting the flag.
- R8: A bus write to channel register n (address 8+n) in the same cycle as a capture on that channel keeps the written value, and the flag is still set.
- R9: `irq_ch[n]` is high exactly when flag n is set and bit n of the mask register (address 4) is 1.
- R10: Register reads return the fields at the addresses above. Unused bits and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cap_in | input | 8 | Capture inputs, asynchronous |
| oc_pin | output | 8 | Compare outputs |
| irq_ch | output | 8 | Per-channel interrupt requests |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a capture that lands in the same cycle as a bus write or a flag clear. Because of the synchroniser, the capture occurs two edges after the input edge. The stimulus therefore toggles the input and starts the conflicting bus strobe exactly two falling edges later, so both act on the same rising edge.

The second is the overflow, which needs the full 65536-step wrap. The bench lets the counter run through it with a compare channel parked at zero, so the wrap and a match coincide. A behavioural model tracks every register, and the bench compares all outputs and the addressed read data on every clock.

// File: rtl/tcc_unit.sv
module tcc_unit #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic [NCH-1:0] cap_in,
  output logic [NCH-1:0] oc_pin,
  output logic [NCH-1:0] irq_ch,
  output logic          irq_ovf
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_ACT  = AW'(2);
  localparam logic [AW-1:0] A_EDGE = AW'(3);
  localparam logic [AW-1:0] A_MASK = AW'(4);
  localparam logic [AW-1:0] A_FLAG = AW'(5);
  localparam logic [AW-1:0] A_OVF  = AW'(6);
  localparam logic [AW-1:0] A_CNT  = AW'(7);
  localparam int CHW = 3;

  logic            ten, ovie, ovf;
  logic [CW-1:0]   cnt, cnt_nx;
  logic [NCH-1:0]  mode, mask, flag, hit, clr, pin;
  logic [2*NCH-1:0] act, edg;
  logic [NCH-1:0]  s1, s2, s3;
  logic [CW-1:0]   chr [NCH];

  assign cnt_nx  = cnt + CW'(1);
  assign clr     = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[NCH-1:0] : '0;
  assign oc_pin  = pin;
  assign irq_ch  = flag & mask;
  assign irq_ovf = ovf & ovie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten <= 1'b0; ovie <= 1'b0; ovf <= 1'b0; cnt <= '0;
      mode <= '0; mask <= '0; flag <= '0; act <= '0; edg <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      if (ten) cnt <= cnt_nx;
      ovf  <= (ovf & ~(bus_wr && bus_addr == A_OVF && bus_wdata[0])) | (ten && cnt == '1);
      flag <= (flag & ~clr) | hit;
      s1 <= cap_in; s2 <= s1; s3 <= s2;
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: begin ten <= bus_wdata[7]; ovie <= bus_wdata[0]; end
          A_MODE: mode <= bus_wdata[NCH-1:0];
          A_ACT:  act  <= bus_wdata[2*NCH-1:0];
          A_EDGE: edg  <= bus_wdata[2*NCH-1:0];
          A_MASK: mask <= bus_wdata[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] MY_ADR = AW'(8 + i);
    logic rise, fall, cap_hit, cmp_hit, wr_me;
    logic [1:0] e, a;
    assign e       = edg[2*i +: 2];
    assign a       = act[2*i +: 2];
    assign rise    = s2[i] & ~s3[i];
    assign fall    = ~s2[i] & s3[i];
    assign cap_hit = ~mode[i] & ((e == 2'b01 & rise) | (e == 2'b10 & fall) | (e == 2'b11 & (rise | fall)));
    assign cmp_hit = mode[i] & ten & (cnt_nx == chr[i]);
    assign hit[i]  = cap_hit | cmp_hit;
    assign wr_me   = bus_wr && bus_addr == MY_ADR;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chr[i] <= '0;
        pin[i] <= 1'b0;
      end else begin
        if (wr_me) chr[i] <= bus_wdata;
        else if (cap_hit) chr[i] <= cnt;
        if (cmp_hit) begin
          case (a)
            2'b01: pin[i] <= ~pin[i];
            2'b10: pin[i] <= 1'b0;
            2'b11: pin[i] <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin bus_rdata[7] = ten; bus_rdata[0] = ovie; end
      A_MODE: bus_rdata[NCH-1:0] = mode;
      A_ACT:  bus_rdata[2*NCH-1:0] = act;
      A_EDGE: bus_rdata[2*NCH-1:0] = edg;
      A_MASK: bus_rdata[NCH-1:0] = mask;
      A_FLAG: bus_rdata[NCH-1:0] = flag;
      A_OVF:  bus_rdata[0] = ovf;
      A_CNT:  bus_rdata = cnt;
      default:
        if (bus_addr[AW-1:CHW] == (AW-CHW)'(1) && int'(bus_addr[CHW-1:0]) < NCH)
          bus_rdata = chr[bus_addr[CHW-1:0]];
    endcase
  end
endmodule

module tcc_unit_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [CW-1:0]  bus_wdata,
  input logic [NCH-1:0] oc_pin,
  input logic           ten,
  input logic [CW-1:0]  cnt,
  input logic           ovf,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] mode
);
  logic [NCH-1:0] clrm;
  logic           ovclr;
  assign clrm  = (bus_wr && bus_addr == AW'(5)) ? bus_wdata[NCH-1:0] : '0;
  assign ovclr = bus_wr && bus_addr == AW'(6) && bus_wdata[0];

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ten |=> $stable(cnt));
  a_r2_step_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    ten |=> cnt == CW'($past(cnt) + CW'(1)));
  a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ten && cnt == '1) |=> ovf);
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovclr) |=> ovf);
  a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag) & ~$past(clrm) & ~flag) == '0));
  a_r5_capture_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((oc_pin ^ $past(oc_pin)) & ~$past(mode)) == '0));
  a_r6_no_action_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ten |=> $stable(oc_pin));
endmodule

bind tcc_unit tcc_unit_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .oc_pin(oc_pin), .ten(ten), .cnt(cnt),
  .ovf(ovf), .flag(flag), .mode(mode)
);

// File: tb/sim_tcc_unit.sv
module sim_tcc_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  cap_in = '0;
  logic [7:0]  oc_pin, irq_ch;
  logic        irq_ovf;

  int total = 0, bad = 0;
  bit done = 0;

  tcc_unit u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
               .cap_in, .oc_pin, .irq_ch, .irq_ovf);

  logic [15:0] m_cnt, m_act, m_edg;
  logic        m_ten, m_ovie, m_ovf;
  logic [7:0]  m_mode, m_mask, m_flag, m_pin, m_s1, m_s2, m_s3;
  logic [15:0] m_ch [8];

  always @(posedge clk) begin : mdl
    logic [7:0]  hits, clr, npin;
    logic [15:0] nch [8];
    logic [1:0]  f;
    logic        r, fl, ovset;
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_edg = 0; m_ten = 0; m_ovie = 0; m_ovf = 0;
      m_mode = 0; m_mask = 0; m_flag = 0; m_pin = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      for (int i = 0; i < 8; i++) m_ch[i] = 0;
    end else begin
      hits = 0; npin = m_pin;
      for (int i = 0; i < 8; i++) nch[i] = m_ch[i];
      for (int i = 0; i < 8; i++) begin
        r  = m_s2[i] & ~m_s3[i];
        fl = ~m_s2[i] & m_s3[i];
        if (!m_mode[i]) begin
          f = m_edg[2*i +: 2];
          if ((f == 1 && r) || (f == 2 && fl) || (f == 3 && (r || fl))) begin
            hits[i] = 1; nch[i] = m_cnt;
          end
        end else if (m_ten && 16'(m_cnt + 16'd1) == m_ch[i]) begin
          hits[i] = 1; f = m_act[2*i +: 2];
          if (f == 1) npin[i] = ~m_pin[i];
          else if (f == 2) npin[i] = 0;
          else if (f == 3) npin[i] = 1;
        end
      end
      ovset = m_ten && m_cnt == 16'hFFFF;
      clr = (bus_wr && bus_addr == 5) ? bus_wdata[7:0] : 8'h00;
      m_flag = (m_flag & ~clr) | hits;
      m_ovf = (m_ovf & !(bus_wr && bus_addr == 6 && bus_wdata[0])) | ovset;
      if (m_ten) m_cnt = 16'(m_cnt + 16'd1);
      if (bus_wr) begin
        case (bus_addr)
          0: begin m_ten = bus_wdata[7]; m_ovie = bus_wdata[0]; end
          1: m_mode = bus_wdata[7:0];
          2: m_act = bus_wdata;
          3: m_edg = bus_wdata;
          4: m_mask = bus_wdata[7:0];
          default: if (bus_addr >= 8 && bus_addr < 16) nch[bus_addr - 8] = bus_wdata;
        endcase
      end
      for (int i = 0; i < 8; i++) m_ch[i] = nch[i];
      m_pin = npin;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    end
  end

  function automatic logic [15:0] exp_rd(logic [4:0] a);
    case (a)
      0: return {8'h00, m_ten, 6'b0, m_ovie};
      1: return {8'h00, m_mode};
      2: return m_act;
      3: return m_edg;
      4: return {8'h00, m_mask};
      5: return {8'h00, m_flag};
      6: return {15'b0, m_ovf};
      7: return m_cnt;
      default: return (a >= 8 && a < 16) ? m_ch[a - 8] : 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    if (!rst_n) return "R1";
    case (a)
      0, 7: return "R2";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R9";
      5: return "R4";
      6: return "R3";
      default: return (a >= 8 && a < 16) ? "R7/R8" : "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk(rst_n ? "R6" : "R1", "oc_pin", {8'h00, oc_pin}, {8'h00, m_pin});
      chk(rst_n ? "R9" : "R1", "irq_ch", {8'h00, irq_ch}, {8'h00, m_flag & m_mask});
      chk(rst_n ? "R3" : "R1", "irq_ovf", {15'b0, irq_ovf}, {15'b0, m_ovf & m_ovie});
      chk(tag_of(bus_addr), "rdata", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(logic [4:0] a, logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      bus_addr = 5'(k % 20);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1 reset state, R10 map walk
    @(negedge clk); idle(20);
    rst_n = 1; idle(20);
    // R5/R6/R7 setup: ch0..3 compare, ch4..7 capture
    wr(1, 16'h000F);
    wr(2, 16'h0039);
    wr(3, 16'h3900);
    wr(4, 16'h00FF);
    wr(8, 16'd20); wr(9, 16'd25); wr(10, 16'd30); wr(11, 16'd35);
    wr(17, 16'hBEEF);               // R10 unmapped write
    wr(7, 16'h1234);                // R2 counter read-only
    idle(10);
    wr(0, 16'h0081);                // R2 run, overflow irq on
    idle(60);
    // R7 captures on various edges
    cap_in = 8'hF0; idle(8);
    cap_in = 8'h00; idle(8);
    cap_in[6] = 1; idle(5);
    // R5 edges on compare channel ignored
    cap_in[0] = 1; idle(6); cap_in[0] = 0; idle(6);
    // R4 W1C: zero keeps, one clears
    wr(5, 16'h0000); idle(3);
    wr(5, 16'h00A5); idle(3);
    wr(5, 16'h00FF); idle(3);
    // R4 capture and clear on same edge
    cap_in[6] = 0; @(negedge clk); @(negedge clk); wr(5, 16'h0040); idle(4);
    // R8 capture and channel write on same edge
    cap_in[4] = 1; @(negedge clk); @(negedge clk); wr(12, 16'hA5A5); idle(4);
    bus_addr = 12; @(negedge clk);
    // R2 hold while stopped, R6 no match while stopped
    wr(0, 16'h0001); idle(30);
    cap_in[7] = 1; idle(5);         // R7 edge field 00 ignored
    wr(0, 16'h0081);
    // R6 re-arm near current count, R9 mask off
    wr(4, 16'h000F);
    wr(8, 16'(m_cnt + 16'd6)); idle(12);
    // R3/R6 wrap with compare at zero
    wr(11, 16'h0000);
    wr(2, 16'h00F9);
    idle(65600);
    wr(0, 16'h0080); idle(4);       // R3 enable gates irq
    wr(6, 16'h0000); idle(3);
    wr(6, 16'h0001); idle(3);
    wr(1, 16'h00F0);                // R5 swap roles
    wr(3, 16'h00FF);
    cap_in = 8'h0F; idle(8);
    cap_in = 8'h00; idle(8);
    finish_run();
  end
endmodule